// File: doc/BRIEF.md
# Instruction Fetch Stage Controller

This block is the per-cycle control for the fetch stage of an out-of-order core. Every cycle it reads squash, mispredict and stall indications from the later stages (decode, rename, execute, commit), an instruction-cache miss-complete pulse, a miss indication for the access issued this cycle, and a fault flag for that access. From these it picks the stage state, decides whether a fetch group is produced, and whether a new cache access is issued. It drives the fetch PC and next PC, a cancel request for an outstanding miss, and squash and update commands to the branch predictor.

The fetch-group datapath supplies `grp_next_pc`, the address that follows the group it assembles. The controller adopts it whenever a fetch completes without a miss or a fault. Four saturating counters record the cycles spent fetching, squashing, blocked and waiting on a miss.

State codes used on `state`: 0 Idle, 1 Running, 2 Squashing, 3 Blocked, 4 MissStall, 5 MissComplete. All decision outputs are combinational from the current state and inputs. State, PC and counters are registered.

Top module: `fetch_ctl`

## Requirements
- R1: While `rst_n` is low and after it is released, the state is Idle (0), `pc` equals `RESET_PC`, `npc` equals `RESET_PC + INST_BYTES`, and all four counters are zero.
- R2: A commit squash has top priority. It redirects `pc` to `cmt_target`, enters Squashing, produces no fetch, and counts one squash cycle. It sends a predictor squash carrying `cmt_seq`. If `cmt_mispred` is set, the squash also carries the fix flag, target `cmt_target` and `cmt_taken`; otherwise fix, target and taken are zero. In MissStall it also raises `miss_cancel`.
- R3: Without a commit squash, a nonzero `cmt_seq` raises `bp_update` with `bp_upd_seq = cmt_seq` in the same cycle.
- R4: Without a commit squash, `cmt_rob_busy` holds the stage in Squashing for the next cycle, suppresses fetch and counts a squash cycle.
- R5: A decode squash, when no commit squash or ROB-busy applies, always sends a predictor squash with the decode sequence number (mispredict details when flagged). It redirects to `dec_target`, enters Squashing and cancels a pending miss only when the state is not already Squashing.
- R6: If any of the four stall inputs is high, with no squash taking effect, the next state is Blocked from any state and a blocked cycle is counted. The first stall-free cycle in Blocked moves to Running without fetching and is also counted as blocked.
- R7: With no squash or stall taking effect, the states Idle, Running and Squashing fetch: `fetch_go` and `access_go` are high and a fetch cycle is counted. If the access neither misses nor faults, the next state is Running and `pc` takes `grp_next_pc`.
- R8: A fetch whose access reports `cache_miss` moves to MissStall with `pc` unchanged. MissStall never fetches and counts a miss cycle each cycle. A `miss_done` pulse there moves it to MissComplete. The next fetch from MissComplete raises `fetch_go` without `access_go`, adopts `grp_next_pc` and goes to Running.
- R9: `miss_done` in any state other than MissStall has no effect: a Running stage keeps issuing a fresh access.
- R10: A fault on an issued access forces Blocked and leaves `pc` unchanged. A fault takes precedence over a miss.
- R11: After every cycle, `npc` equals `pc + INST_BYTES`, including after a redirect.
- R12: Each counter increments by one in the cycles that count for it and holds at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmt_squash | input | 1 | Squash from commit |
| cmt_mispred | input | 1 | Commit squash is a branch mispredict |
| cmt_taken | input | 1 | Resolved direction of the commit branch |
| cmt_seq | input | SEQ_W | Completed sequence number from commit |
| cmt_target | input | ADDR_W | Redirect address from commit |
| cmt_rob_busy | input | 1 | Reorder buffer still squashing |
| cmt_stall | input | 1 | Stall from commit |
| dec_squash | input | 1 | Squash from decode |
| dec_mispred | input | 1 | Decode squash is a mispredict |
| dec_taken | input | 1 | Resolved direction from decode |
| dec_seq | input | SEQ_W | Sequence number from decode |
| dec_target | input | ADDR_W | Redirect address from decode |
| dec_stall | input | 1 | Stall from decode |
| ren_stall | input | 1 | Stall from rename |
| exe_stall | input | 1 | Stall from execute |
| miss_done | input | 1 | Outstanding cache miss completed |
| cache_miss | input | 1 | Access issued this cycle missed |
| fault | input | 1 | Access issued this cycle faulted |
| grp_next_pc | input | ADDR_W | Address after the current fetch group |
| state | output | 3 | Current stage state |
| pc | output | ADDR_W | Fetch PC |
| npc | output | ADDR_W | Next sequential PC |
| fetch_go | output | 1 | A fetch group is produced this cycle |
| access_go | output | 1 | A new cache access is issued this cycle |
| miss_cancel | output | 1 | Cancel the outstanding cache miss |
| bp_squash | output | 1 | Predictor squash command |
| bp_sq_seq | output | SEQ_W | Sequence number of the squash |
| bp_sq_fix | output | 1 | Squash carries mispredict correction |
| bp_sq_target | output | ADDR_W | Corrected target |
| bp_sq_taken | output | 1 | Corrected direction |
| bp_update | output | 1 | Predictor update command |
| bp_upd_seq | output | SEQ_W | Sequence number to update |
| cnt_fetch | output | CNT_W | Fetch cycles |
| cnt_squash | output | CNT_W | Squash cycles |
| cnt_block | output | CNT_W | Blocked cycles |
| cnt_miss | output | CNT_W | Miss-stall cycles |

## Verification
The hardest situations to reach are the stacked ones. Examples are a decode squash arriving while the stage is already Squashing, a squash landing in MissStall, and a completion pulse arriving after the miss it belonged to was squashed. Each needs a specific earlier history of misses and squashes. The bench drives a long weighted-random stream where miss, squash and stall inputs are each likely enough to chain. It predicts every output cycle by cycle from the requirements and uses narrow counters so saturation is reached. A directed pass puts a stale completion pulse into Running.

// File: rtl/fetch_ctl.sv
module fetch_ctl #(
  parameter int ADDR_W = 32,
  parameter int SEQ_W = 16,
  parameter int INST_BYTES = 4,
  parameter int CNT_W = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmt_squash,
  input  logic              cmt_mispred,
  input  logic              cmt_taken,
  input  logic [SEQ_W-1:0]  cmt_seq,
  input  logic [ADDR_W-1:0] cmt_target,
  input  logic              cmt_rob_busy,
  input  logic              cmt_stall,
  input  logic              dec_squash,
  input  logic              dec_mispred,
  input  logic              dec_taken,
  input  logic [SEQ_W-1:0]  dec_seq,
  input  logic [ADDR_W-1:0] dec_target,
  input  logic              dec_stall,
  input  logic              ren_stall,
  input  logic              exe_stall,
  input  logic              miss_done,
  input  logic              cache_miss,
  input  logic              fault,
  input  logic [ADDR_W-1:0] grp_next_pc,
  output logic [2:0]        state,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] npc,
  output logic              fetch_go,
  output logic              access_go,
  output logic              miss_cancel,
  output logic              bp_squash,
  output logic [SEQ_W-1:0]  bp_sq_seq,
  output logic              bp_sq_fix,
  output logic [ADDR_W-1:0] bp_sq_target,
  output logic              bp_sq_taken,
  output logic              bp_update,
  output logic [SEQ_W-1:0]  bp_upd_seq,
  output logic [CNT_W-1:0]  cnt_fetch,
  output logic [CNT_W-1:0]  cnt_squash,
  output logic [CNT_W-1:0]  cnt_block,
  output logic [CNT_W-1:0]  cnt_miss
);
  localparam logic [2:0] S_IDLE = 3'd0, S_RUN = 3'd1, S_SQ = 3'd2,
                         S_BLK = 3'd3, S_MISS = 3'd4, S_MDONE = 3'd5;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INST_BYTES);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [2:0]        nxt;
  logic              redirect, take_grp;
  logic [ADDR_W-1:0] redir_pc;
  logic              inc_f, inc_s, inc_b, inc_m;
  logic              any_stall;

  assign any_stall = dec_stall | ren_stall | exe_stall | cmt_stall;

  always_comb begin
    nxt = state;
    redirect = 1'b0;
    redir_pc = cmt_target;
    take_grp = 1'b0;
    fetch_go = 1'b0;
    access_go = 1'b0;
    miss_cancel = 1'b0;
    bp_squash = 1'b0;
    bp_sq_seq = '0;
    bp_sq_fix = 1'b0;
    bp_sq_target = '0;
    bp_sq_taken = 1'b0;
    bp_update = 1'b0;
    bp_upd_seq = '0;
    {inc_f, inc_s, inc_b, inc_m} = 4'b0;
    if (cmt_squash) begin
      redirect = 1'b1;
      nxt = S_SQ;
      inc_s = 1'b1;
      miss_cancel = (state == S_MISS);
      bp_squash = 1'b1;
      bp_sq_seq = cmt_seq;
      if (cmt_mispred) begin
        bp_sq_fix = 1'b1;
        bp_sq_target = cmt_target;
        bp_sq_taken = cmt_taken;
      end
    end else begin
      if (cmt_seq != '0) begin
        bp_update = 1'b1;
        bp_upd_seq = cmt_seq;
      end
      if (cmt_rob_busy) begin
        nxt = S_SQ;
        inc_s = 1'b1;
      end else begin
        if (dec_squash) begin
          bp_squash = 1'b1;
          bp_sq_seq = dec_seq;
          if (dec_mispred) begin
            bp_sq_fix = 1'b1;
            bp_sq_target = dec_target;
            bp_sq_taken = dec_taken;
          end
        end
        if (dec_squash && state != S_SQ) begin
          redirect = 1'b1;
          redir_pc = dec_target;
          nxt = S_SQ;
          inc_s = 1'b1;
          miss_cancel = (state == S_MISS);
        end else if (any_stall) begin
          nxt = S_BLK;
          inc_b = 1'b1;
        end else if (state == S_BLK) begin
          nxt = S_RUN;
          inc_b = 1'b1;
        end else if (state == S_MISS) begin
          inc_m = 1'b1;
          if (miss_done) nxt = S_MDONE;
        end else begin
          fetch_go = 1'b1;
          inc_f = 1'b1;
          if (state == S_MDONE) begin
            nxt = S_RUN;
            take_grp = 1'b1;
          end else begin
            access_go = 1'b1;
            if (fault) nxt = S_BLK;
            else if (cache_miss) nxt = S_MISS;
            else begin
              nxt = S_RUN;
              take_grp = 1'b1;
            end
          end
        end
      end
    end
  end

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c, input logic en);
    return (en && c != CMAX) ? c + 1'b1 : c;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      pc <= RESET_PC;
      npc <= RESET_PC + STEP;
      cnt_fetch <= '0;
      cnt_squash <= '0;
      cnt_block <= '0;
      cnt_miss <= '0;
    end else begin
      state <= nxt;
      if (redirect) begin
        pc <= redir_pc;
        npc <= redir_pc + STEP;
      end else if (take_grp) begin
        pc <= grp_next_pc;
        npc <= grp_next_pc + STEP;
      end
      cnt_fetch <= bump(cnt_fetch, inc_f);
      cnt_squash <= bump(cnt_squash, inc_s);
      cnt_block <= bump(cnt_block, inc_b);
      cnt_miss <= bump(cnt_miss, inc_m);
    end
  end
endmodule

// File: rtl/fetch_ctl_chk.sv
module fetch_ctl_chk #(
  parameter int ADDR_W = 32,
  parameter int SEQ_W = 16,
  parameter int INST_BYTES = 4,
  parameter int CNT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmt_squash,
  input logic [SEQ_W-1:0]  cmt_seq,
  input logic [ADDR_W-1:0] cmt_target,
  input logic              cmt_rob_busy,
  input logic              dec_squash,
  input logic              any_stall,
  input logic [2:0]        state,
  input logic [ADDR_W-1:0] pc,
  input logic [ADDR_W-1:0] npc,
  input logic              fetch_go,
  input logic              miss_cancel,
  input logic              bp_squash,
  input logic              bp_update,
  input logic [SEQ_W-1:0]  bp_upd_seq,
  input logic [CNT_W-1:0]  cnt_fetch
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INST_BYTES);

  assert_cmt_redirect_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_squash |=> (state == 3'd2 && pc == $past(cmt_target)));
  assert_cmt_nofetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_squash |-> (!fetch_go && bp_squash));
  assert_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmt_squash && cmt_seq != '0) |-> (bp_update && bp_upd_seq == cmt_seq));
  assert_rob_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmt_squash && cmt_rob_busy) |=> state == 3'd2);
  assert_unblock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd3 && !cmt_squash && !cmt_rob_busy && !dec_squash && !any_stall)
    |-> ##1 state == 3'd1);
  assert_miss_nofetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    state == 3'd4 |-> !fetch_go);
  assert_cancel_only_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
    miss_cancel |-> state == 3'd4);
  assert_npc_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    npc == pc + STEP);
  assert_cnt_monotone_R12: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cnt_fetch >= $past(cnt_fetch));
endmodule

bind fetch_ctl fetch_ctl_chk #(.ADDR_W(ADDR_W), .SEQ_W(SEQ_W), .INST_BYTES(INST_BYTES), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmt_squash(cmt_squash), .cmt_seq(cmt_seq),
  .cmt_target(cmt_target), .cmt_rob_busy(cmt_rob_busy), .dec_squash(dec_squash),
  .any_stall(any_stall), .state(state), .pc(pc), .npc(npc), .fetch_go(fetch_go),
  .miss_cancel(miss_cancel), .bp_squash(bp_squash), .bp_update(bp_update),
  .bp_upd_seq(bp_upd_seq), .cnt_fetch(cnt_fetch));

// File: tb/fetch_ctl_tb_top.sv
module fetch_ctl_tb_top;
  localparam int AW = 16, SW = 8, IB = 4, CW = 4;
  localparam logic [AW-1:0] RPC = 16'h0100;

  logic clk = 0, rst_n = 0;
  logic cmt_squash = 0, cmt_mispred = 0, cmt_taken = 0, cmt_rob_busy = 0, cmt_stall = 0;
  logic [SW-1:0] cmt_seq = '0, dec_seq = '0;
  logic [AW-1:0] cmt_target = '0, dec_target = '0, grp_next_pc = '0;
  logic dec_squash = 0, dec_mispred = 0, dec_taken = 0, dec_stall = 0;
  logic ren_stall = 0, exe_stall = 0, miss_done = 0, cache_miss = 0, fault = 0;
  logic [2:0] state;
  logic [AW-1:0] pc, npc, bp_sq_target;
  logic fetch_go, access_go, miss_cancel, bp_squash, bp_sq_fix, bp_sq_taken, bp_update;
  logic [SW-1:0] bp_sq_seq, bp_upd_seq;
  logic [CW-1:0] cnt_fetch, cnt_squash, cnt_block, cnt_miss;

  fetch_ctl #(.ADDR_W(AW), .SEQ_W(SW), .INST_BYTES(IB), .CNT_W(CW), .RESET_PC(RPC)) dut_i (.*);

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // model state
  logic [2:0] m_st;
  logic [AW-1:0] m_pc;
  logic [CW-1:0] m_cf, m_cs, m_cb, m_cm;
  // expected combinational outputs
  logic e_fetch, e_acc, e_cancel, e_sq, e_fix, e_tk, e_upd;
  logic [SW-1:0] e_sqseq, e_updseq;
  logic [AW-1:0] e_tgt;
  logic [2:0] n_st;
  logic [AW-1:0] n_pc;
  logic i_f, i_s, i_b, i_m;
  string tag;

  task automatic check(input bit ok, input string t, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] sat(input logic [CW-1:0] c, input logic en);
    return (en && c != {CW{1'b1}}) ? c + 1'b1 : c;
  endfunction

  task automatic predict();
    logic stall;
    stall = dec_stall | ren_stall | exe_stall | cmt_stall;
    n_st = m_st; n_pc = m_pc;
    {e_fetch, e_acc, e_cancel, e_sq, e_fix, e_tk, e_upd} = '0;
    e_sqseq = '0; e_updseq = '0; e_tgt = '0;
    {i_f, i_s, i_b, i_m} = '0;
    if (cmt_squash) begin
      tag = "R2"; n_st = 2; n_pc = cmt_target; i_s = 1;
      e_cancel = (m_st == 4); e_sq = 1; e_sqseq = cmt_seq;
      if (cmt_mispred) begin e_fix = 1; e_tgt = cmt_target; e_tk = cmt_taken; end
    end else begin
      if (cmt_seq != 0) begin e_upd = 1; e_updseq = cmt_seq; end
      if (cmt_rob_busy) begin tag = "R4"; n_st = 2; i_s = 1; end
      else begin
        if (dec_squash) begin
          e_sq = 1; e_sqseq = dec_seq;
          if (dec_mispred) begin e_fix = 1; e_tgt = dec_target; e_tk = dec_taken; end
        end
        if (dec_squash && m_st != 2) begin
          tag = "R5"; n_st = 2; n_pc = dec_target; i_s = 1; e_cancel = (m_st == 4);
        end else if (stall) begin tag = "R6"; n_st = 3; i_b = 1; end
        else if (m_st == 3) begin tag = "R6"; n_st = 1; i_b = 1; end
        else if (m_st == 4) begin
          tag = "R8"; i_m = 1; if (miss_done) n_st = 5;
        end else begin
          e_fetch = 1; i_f = 1;
          if (m_st == 5) begin tag = "R8"; n_st = 1; n_pc = grp_next_pc; end
          else begin
            e_acc = 1;
            if (fault) begin tag = "R10"; n_st = 3; end
            else if (cache_miss) begin tag = "R8"; n_st = 4; end
            else begin tag = (miss_done ? "R9" : "R7"); n_st = 1; n_pc = grp_next_pc; end
          end
        end
      end
    end
  endtask

  task automatic cycle_check();
    predict();
    #1;
    check({fetch_go, access_go, miss_cancel} == {e_fetch, e_acc, e_cancel}, tag,
          "fetch/access/cancel", {fetch_go, access_go, miss_cancel}, {e_fetch, e_acc, e_cancel});
    check({bp_squash, bp_sq_seq, bp_sq_fix, bp_sq_target, bp_sq_taken} ==
          {e_sq, e_sqseq, e_fix, e_tgt, e_tk}, cmt_squash ? "R2" : "R5", "bp squash",
          {bp_squash, bp_sq_seq, bp_sq_fix, bp_sq_target, bp_sq_taken},
          {e_sq, e_sqseq, e_fix, e_tgt, e_tk});
    check({bp_update, bp_upd_seq} == {e_upd, e_updseq}, "R3", "bp update",
          {bp_update, bp_upd_seq}, {e_upd, e_updseq});
    m_st = n_st; m_pc = n_pc;
    m_cf = sat(m_cf, i_f); m_cs = sat(m_cs, i_s); m_cb = sat(m_cb, i_b); m_cm = sat(m_cm, i_m);
    @(posedge clk); #1;
    check({state, pc} == {m_st, m_pc}, tag, "state/pc", {state, pc}, {m_st, m_pc});
    check(npc == m_pc + AW'(IB), "R11", "npc", npc, m_pc + AW'(IB));
    check({cnt_fetch, cnt_squash, cnt_block, cnt_miss} == {m_cf, m_cs, m_cb, m_cm}, "R12",
          "counters", {cnt_fetch, cnt_squash, cnt_block, cnt_miss}, {m_cf, m_cs, m_cb, m_cm});
  endtask

  task automatic idle_inputs();
    {cmt_squash, cmt_mispred, cmt_taken, cmt_rob_busy, cmt_stall} = '0;
    {dec_squash, dec_mispred, dec_taken, dec_stall, ren_stall, exe_stall} = '0;
    {miss_done, cache_miss, fault} = '0;
    cmt_seq = '0; dec_seq = '0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog run did not complete");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    repeat (3) @(posedge clk);
    #1;
    check({state, pc, npc} == {3'd0, RPC, RPC + AW'(IB)}, "R1", "reset regs",
          {state, pc, npc}, {3'd0, RPC, RPC + AW'(IB)});
    check({cnt_fetch, cnt_squash, cnt_block, cnt_miss} == '0, "R1", "reset counters",
          {cnt_fetch, cnt_squash, cnt_block, cnt_miss}, 0);
    @(negedge clk); rst_n = 1;
    m_st = 0; m_pc = RPC; m_cf = 0; m_cs = 0; m_cb = 0; m_cm = 0;

    // directed: stale completion pulse in Idle and Running (R9)
    for (int k = 0; k < 3; k++) begin
      grp_next_pc = m_pc + 16'd8;
      miss_done = 1;
      cycle_check();
      @(negedge clk);
    end
    check(state == 3'd1, "R9", "stays Running after stale pulse", state, 1);
    miss_done = 0;

    // directed: miss then complete, squash during miss (R8, R2)
    cache_miss = 1; cycle_check(); @(negedge clk); cache_miss = 0;
    cycle_check(); @(negedge clk);
    miss_done = 1; cycle_check(); @(negedge clk); miss_done = 0;
    grp_next_pc = 16'h0400; cycle_check(); @(negedge clk);
    cache_miss = 1; cycle_check(); @(negedge clk); cache_miss = 0;
    cmt_squash = 1; cmt_mispred = 1; cmt_taken = 1; cmt_target = 16'h2000; cmt_seq = 8'h11;
    cycle_check(); @(negedge clk); idle_inputs();
    dec_squash = 1; dec_target = 16'h3000; dec_seq = 8'h22; // ignored redirect while Squashing
    cycle_check(); @(negedge clk); idle_inputs();

    // weighted random sweep
    for (int i = 0; i < 6000; i++) begin
      cmt_squash = ($urandom_range(15) == 0);
      cmt_mispred = $urandom_range(1); cmt_taken = $urandom_range(1);
      cmt_seq = ($urandom_range(2) == 0) ? SW'($urandom_range(255)) : '0;
      cmt_target = AW'($urandom) & ~AW'(3);
      cmt_rob_busy = ($urandom_range(11) == 0);
      cmt_stall = ($urandom_range(19) == 0);
      dec_squash = ($urandom_range(7) == 0);
      dec_mispred = $urandom_range(1); dec_taken = $urandom_range(1);
      dec_seq = SW'($urandom_range(255));
      dec_target = AW'($urandom) & ~AW'(3);
      dec_stall = ($urandom_range(19) == 0);
      ren_stall = ($urandom_range(19) == 0);
      exe_stall = ($urandom_range(19) == 0);
      miss_done = ($urandom_range(3) == 0);
      cache_miss = ($urandom_range(3) == 0);
      fault = ($urandom_range(19) == 0);
      grp_next_pc = m_pc + AW'(4 * $urandom_range(1, 8));
      cycle_check();
      @(negedge clk);
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule